// File: doc/BRIEF.md
# Legacy INTx pulse interrupt aggregator

This block merges four level-sensitive legacy PCI interrupt lines onto a single interrupt output that a system interrupt controller sees as edge-only. Each line has an enable bit and a sticky pending bit. The output gives a one-cycle pulse whenever an enabled line goes active.

An edge-only output loses the level meaning of the inputs: a line that stays high after its handler runs would never be seen again. To keep that meaning, software writes an end-of-interrupt register when a handler finishes. The block then checks the named line again and sends a fresh pulse if the line is still enabled and high. Software reaches every register through a simple single-cycle write strobe and a combinational read port.

The end-of-interrupt write names a line in reverse order. Index k selects line 3-k, so index 3 refers to pending bit 0.

Top module: `intx_pulse_agg`

## Requirements
- R1: A synchronous active-low reset clears the enable bits, the pending bits and the pulse output. While reset is held the output stays low, and after reset both the enable register and the status register read zero.
- R2: A write to address 0x100 loads the enable bits from data bits 3:0, where bit i enables line i. A read of 0x100 returns those four bits with all upper bits zero.
- R3: Pending bit i becomes set in the cycle after line i is high while enabled. A line that is not enabled never sets its pending bit. A read of 0x500 returns the pending bits in bits 3:0 and zero in all upper bits.
- R4: A write to 0x700 with a one in data bit i clears pending bit i. If line i is enabled and high in that same cycle, the bit stays set. Zero data bits leave their pending bits unchanged.
- R5: When an enabled line goes from inactive to active (high and enabled), the output is high for exactly one cycle, in the cycle after that change.
- R6: Rising edges on several lines in the same cycle produce one single-cycle pulse. A line held active produces no further pulses.
- R7: A write to 0x010 carries an index k in data bits 1:0 and selects line 3-k. If that line is enabled and high, the output pulses in the next cycle.
- R8: An end-of-interrupt write that selects a line that is low, or high but not enabled, produces no pulse.
- R9: An end-of-interrupt hit and a rising edge in the same cycle produce one single-cycle pulse.
- R10: Reads of 0x010, 0x700 and any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_lvl | input | 4 | Legacy interrupt levels, bit i is line i (bit 0 = INTA), synchronous to clk |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 12 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_pulse | output | 1 | One-cycle interrupt pulse toward the interrupt controller |

## Verification
Two things can ask for a pulse in the same cycle: a rising edge on an enabled line, and an end-of-interrupt write that finds its selected line still active. The bench causes both at once. It raises line 3 in the same cycle that it writes the end-of-interrupt register for a line that is already active. It expects one high cycle followed by a low cycle, not a stretched or doubled pulse. The same kind of collision happens inside the pending logic: a clear is written in the same cycle that its line is still active, and the bit must stay set.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;

  // Map an end-of-interrupt index onto a line number (reverse order).
  function automatic int unsigned eoi_to_line(input int unsigned idx,
                                              input int unsigned n_lines);
    return n_lines - 1 - idx;
  endfunction

  // Lines whose active condition went from low to high.
  function automatic logic [7:0] rising_lines(input logic [7:0] now_v,
                                              input logic [7:0] was_v);
    return now_v & ~was_v;
  endfunction

endpackage

// File: rtl/intx_regfile.sv
module intx_regfile #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] A_EOI = 12'h010,
  parameter logic [ADDR_W-1:0] A_EN  = 12'h100,
  parameter logic [ADDR_W-1:0] A_ST  = 12'h500,
  parameter logic [ADDR_W-1:0] A_CLR = 12'h700
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [N_LINES-1:0]   status,
  output logic [N_LINES-1:0]   en_q,
  output logic [N_LINES-1:0]   clr_mask,
  output logic                 eoi_req,
  output logic [IDX_W-1:0]     eoi_idx,
  output logic [DATA_W-1:0]    rdata
);
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic wr_en_reg;
  assign wr_en_reg = wr && (addr == A_EN);
  assign clr_mask  = (wr && (addr == A_CLR)) ? wdata[N_LINES-1:0] : '0;
  assign eoi_req   = wr && (addr == A_EOI);
  assign eoi_idx   = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= wdata[N_LINES-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_EN)      rdata[N_LINES-1:0] = en_q;
    else if (addr == A_ST) rdata[N_LINES-1:0] = status;
  end

  // R2: the enable register takes the written low bits
  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EN) |=> (en_q == $past(wdata[N_LINES-1:0])));

  // R3: the upper status bits always read zero
  p_st_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ST) |-> (rdata[DATA_W-1:N_LINES] == '0));

endmodule

// File: rtl/intx_pending.sv
module intx_pending #(
  parameter int unsigned N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] cond,
  input  logic [N_LINES-1:0] clr_mask,
  output logic [N_LINES-1:0] status_q
);

  // A set from a still-active line wins over a clear.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | cond;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    // R3: an active line always leaves its bit set
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cond[g] |=> status_q[g]);
    // R4: a clear on an idle line empties the bit
    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[g] && !cond[g]) |=> !status_q[g]);
  end

endmodule

// File: rtl/intx_pulse_gen.sv
module intx_pulse_gen
  import intx_agg_pkg::*;
#(
  parameter int unsigned N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] cond,
  input  logic               eoi_req,
  input  logic [IDX_W-1:0]   eoi_idx,
  output logic               rise_any,
  output logic               eoi_hit,
  output logic               pulse_q
);
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] cond_q;
  logic [7:0]         rise_v;
  logic               sel_active;

  assign rise_v   = rising_lines(8'(cond), 8'(cond_q));
  assign rise_any = |rise_v;

  always_comb begin
    sel_active = 1'b0;
    if (int'(eoi_idx) < int'(N_LINES))
      sel_active = cond[eoi_to_line(int'(eoi_idx), N_LINES)];
  end
  assign eoi_hit = eoi_req && sel_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      cond_q  <= cond;
      pulse_q <= rise_any || eoi_hit;
    end
  end

  // R5: a new active line is followed by a pulse
  p_rise_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cond & ~$past(cond))) |=> pulse_q);

  // R6: an unchanged level with no end-of-interrupt gives no pulse
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond == $past(cond)) && !eoi_req) |=> !pulse_q);

  // R8: an end-of-interrupt on an inactive line gives no pulse
  p_eoi_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !sel_active && (cond == $past(cond))) |=> !pulse_q);

endmodule

// File: rtl/intx_pulse_agg.sv
module intx_pulse_agg #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  intx_lvl,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_pulse
);
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] en_q;
  logic [N_LINES-1:0] clr_mask;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] line_active;
  logic               eoi_req;
  logic [IDX_W-1:0]   eoi_idx;
  logic               rise_any;
  logic               eoi_hit;

  assign line_active = intx_lvl & en_q;

  intx_regfile #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status_q), .en_q(en_q), .clr_mask(clr_mask),
    .eoi_req(eoi_req), .eoi_idx(eoi_idx), .rdata(reg_rdata)
  );

  intx_pending #(.N_LINES(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .cond(line_active), .clr_mask(clr_mask),
    .status_q(status_q)
  );

  intx_pulse_gen #(.N_LINES(N_LINES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .cond(line_active), .eoi_req(eoi_req),
    .eoi_idx(eoi_idx), .rise_any(rise_any), .eoi_hit(eoi_hit),
    .pulse_q(irq_pulse)
  );

  // R1: reset empties all state and silences the output
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq_pulse && en_q == '0 && status_q == '0));

  // R9: two causes in one cycle still give a single pulse
  p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_any && eoi_hit) |=> irq_pulse);

endmodule

// File: tb/tb_intx_pulse_agg.sv
module tb_intx_pulse_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lvl;
  logic        wr;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  intx_pulse_agg dut (
    .clk(clk), .rst_n(rst_n), .intx_lvl(lvl), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_pulse(irq)
  );

  int    errs = 0;
  int    checks = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [3:0] m_en = '0, m_prev = '0, m_stat = '0, lvl_r = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected pulse pushed to the scoreboard
  task automatic cyc(input logic [3:0] l, input bit w, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
    logic [3:0] act;
    bit e;
    @(negedge clk);
    lvl = l; wr = w; addr = a; wdata = d; lvl_r = l;
    act = l & m_en;
    e = |(act & ~m_prev);
    if (w && a == 12'h010 && act[3 - int'(d[1:0])]) e = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_prev = act;
    m_stat = (m_stat & ~((w && a == 12'h700) ? d[3:0] : 4'h0)) | act;
    if (w && a == 12'h100) m_en = d[3:0];
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(lvl_r, 1'b0, a, 32'h0, tag);
    #1;
    chk(rdata === exp, tag, "read", rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lvl = '0; wr = 1'b0; lvl_r = '0;
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R1", "pulse in reset", 32'(irq), 32'h0);
    m_en = '0; m_prev = '0; m_stat = '0;
    rst_n = 1'b1;
  endtask

  // Monitor: pops expected pulse values just after each edge
  always @(posedge clk) begin
    bit e;
    string t;
    #5;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(irq === e, t, "pulse", 32'(irq), 32'(e));
    end
  end

  initial begin
    #(20 * 2000);
    errs++;
    $display("FAIL watchdog: actual running expected done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lvl = '0; wr = 1'b0; addr = '0; wdata = '0;
    do_reset();
    rd(12'h100, 32'h0, "R1");
    rd(12'h500, 32'h0, "R1");
    // R2 enable lines 0 and 2, upper bits ignored
    cyc(4'b0000, 1'b1, 12'h100, 32'hFFFF_FFF5, "R2");
    rd(12'h100, 32'h5, "R2");
    // R5 rising edge on line 0, then R6 held level stays quiet
    cyc(4'b0001, 1'b0, 12'h0, 32'h0, "R5");
    cyc(4'b0001, 1'b0, 12'h0, 32'h0, "R6");
    cyc(4'b0001, 1'b0, 12'h0, 32'h0, "R6");
    rd(12'h500, 32'h1, "R3");
    // R3 line 1 high but disabled
    cyc(4'b0011, 1'b0, 12'h0, 32'h0, "R3");
    rd(12'h500, 32'h1, "R3");
    // R4 clears
    cyc(4'b0011, 1'b1, 12'h700, 32'h0, "R4");
    rd(12'h500, 32'h1, "R4");
    cyc(4'b0011, 1'b1, 12'h700, 32'h1, "R4");
    rd(12'h500, 32'h1, "R4");
    cyc(4'b0010, 1'b1, 12'h700, 32'h1, "R4");
    rd(12'h500, 32'h0, "R4");
    // R5 again, then R7 end-of-interrupt on active line 0 (index 3)
    cyc(4'b0011, 1'b0, 12'h0, 32'h0, "R5");
    cyc(4'b0011, 1'b1, 12'h010, 32'h3, "R7");
    cyc(4'b0011, 1'b1, 12'h010, 32'h3, "R7");
    cyc(4'b0011, 1'b0, 12'h0, 32'h0, "R7");
    // R8 index 2 -> line 1 disabled, index 1 -> line 2 low
    cyc(4'b0011, 1'b1, 12'h010, 32'h2, "R8");
    cyc(4'b0011, 1'b1, 12'h010, 32'h1, "R8");
    // enable all: line 1 becomes active
    cyc(4'b0011, 1'b1, 12'h100, 32'hF, "R2");
    cyc(4'b0011, 1'b0, 12'h0, 32'h0, "R5");
    // R6 two lines rise together -> one pulse
    cyc(4'b1111, 1'b0, 12'h0, 32'h0, "R6");
    cyc(4'b1111, 1'b0, 12'h0, 32'h0, "R6");
    cyc(4'b0111, 1'b0, 12'h0, 32'h0, "R6");
    // R9 rising line 3 with end-of-interrupt for line 0
    cyc(4'b1111, 1'b1, 12'h010, 32'h3, "R9");
    cyc(4'b1111, 1'b0, 12'h0, 32'h0, "R9");
    rd(12'h500, 32'hF, "R3");
    rd(12'h010, 32'h0, "R10");
    rd(12'h700, 32'h0, "R10");
    rd(12'h204, 32'h0, "R10");
    // R1 mid-run reset
    cyc(4'b0000, 1'b0, 12'h0, 32'h0, "R1");
    do_reset();
    rd(12'h100, 32'h0, "R1");
    rd(12'h500, 32'h0, "R1");
    cyc(4'b1111, 1'b0, 12'h0, 32'h0, "R1");
    rd(12'h500, 32'h0, "R1");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule